// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic and logic core behind an 8-bit accumulator machine. It holds the accumulator (ACC) and a one-bit data flag (FLG). Each cycle it can replace them with a result formed from a directly presented operand byte, the current ACC and the current FLG. The instruction decoder elsewhere reduces each instruction to a 4-bit operation select and raises a load strobe when ACC and FLG must take the result. Operand fetch and program-counter updates are done by the surrounding machine.

The operations are: a plain load, addition with and without carry-in, and subtraction in both directions (operand minus ACC, and ACC minus operand), each with an optional borrow. They also include AND, OR, XOR, zero-filling shifts in both directions, and ring shifts through the flag. After any subtraction the flag means "no borrow": it is 1 when the true difference is zero or positive. A borrow variant subtracts the inverse of the flag as an extra term. The load and the logic operations leave the flag as it was.

Top module: `accum_alu`

## Requirements
- R1: While `rstN` is low, ACC and FLG are cleared to 0 at each clock edge.
- R2: With `loadEn` low, ACC and FLG keep their values whatever `opSel` and `operand` carry.
- R3: Select 0 (load) writes `operand` into ACC and keeps FLG.
- R4: Select 1 writes {FLG,ACC} = operand + ACC as a 9-bit sum. Select 2 also adds the old FLG, so FLG becomes the carry out of bit 7.
- R5: Select 3 writes ACC = operand − ACC. FLG becomes 1 if operand ≥ ACC and 0 if it is less.
- R6: Select 5 writes ACC = ACC − operand. FLG becomes 1 if ACC ≥ operand and 0 if it is less.
- R7: Selects 4 and 6 work as selects 3 and 5 but also subtract (1 − FLG). FLG afterwards is 1 exactly when the full difference is not negative.
- R8: Selects 7, 8 and 9 write ACC with operand AND, OR and XOR ACC respectively, and keep FLG.
- R9: Select 10 shifts ACC right with 0 entering bit 7, and old bit 0 goes to FLG. Select 12 shifts ACC left with 0 entering bit 0, and old bit 7 goes to FLG.
- R10: Select 11 rotates right through the flag: old FLG enters bit 7 and old bit 0 goes to FLG. Select 13 rotates left: old FLG enters bit 0 and old bit 7 goes to FLG.
- R11: Selects 14 and 15 change neither ACC nor FLG, even with `loadEn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| loadEn | input | 1 | Strobe: commit the selected result this edge |
| opSel | input | 4 | Operation select (codes in R3 to R11) |
| operand | input | 8 | Operand byte from memory or immediate |
| accOut | output | 8 | Current accumulator |
| flagOut | output | 1 | Current data flag |

## Verification
The flag is read as carry-in or borrow and written as carry-out or shifted-out bit at the same edge. So a chained addition or borrowed subtraction must use the flag from before the edge, not the one it produces. The bench forces a known flag value (load a byte, shift it right) right before every operation under test, with both flag values for each select. A 9-bit integer model predicts each {FLG,ACC} result, and the monitor compares it one register stage later.

// File: rtl/accum_alu_pkg.sv
`timescale 1ns/1ps
package accum_alu_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd1;
  localparam logic [OP_W-1:0] OP_ADDC  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUBD  = 4'd3;
  localparam logic [OP_W-1:0] OP_SUBDB = 4'd4;
  localparam logic [OP_W-1:0] OP_SUBM  = 4'd5;
  localparam logic [OP_W-1:0] OP_SUBMB = 4'd6;
  localparam logic [OP_W-1:0] OP_AND   = 4'd7;
  localparam logic [OP_W-1:0] OP_OR    = 4'd8;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd9;
  localparam logic [OP_W-1:0] OP_SHR   = 4'd10;
  localparam logic [OP_W-1:0] OP_RSHR  = 4'd11;
  localparam logic [OP_W-1:0] OP_SHL   = 4'd12;
  localparam logic [OP_W-1:0] OP_RSHL  = 4'd13;

  typedef enum logic [2:0] {
    RES_PASS, RES_SUM, RES_AND, RES_OR, RES_XOR, RES_SHR, RES_SHL
  } resSel_e;

  typedef struct packed {
    logic    accWr;        // commit accumulator
    logic    flagWr;       // commit flag
    resSel_e resSel;       // result source
    logic    swapOps;      // adder A = acc, B = operand
    logic    invB;         // complement adder B (subtract)
    logic    carryFromFlag;// carry-in taken from flag
    logic    carryConst;   // carry-in constant when not from flag
    logic    fillFromFlag; // shift fill bit is the flag (ring)
  } strobe_t;
endpackage

// File: rtl/accum_alu_ctrl.sv
`timescale 1ns/1ps
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic            loadEn,
  input  logic [OP_W-1:0] opSel,
  output strobe_t         strobes
);
  strobe_t dec;

  always_comb begin
    dec        = '0;
    dec.resSel = RES_PASS;
    case (opSel)
      OP_LOAD: begin
        dec.accWr = 1'b1;
      end
      OP_ADD, OP_ADDC: begin
        dec.accWr         = 1'b1;
        dec.flagWr        = 1'b1;
        dec.resSel        = RES_SUM;
        dec.carryFromFlag = (opSel == OP_ADDC);
      end
      OP_SUBD, OP_SUBDB, OP_SUBM, OP_SUBMB: begin
        dec.accWr         = 1'b1;
        dec.flagWr        = 1'b1;
        dec.resSel        = RES_SUM;
        dec.invB          = 1'b1;
        dec.swapOps       = (opSel == OP_SUBM) || (opSel == OP_SUBMB);
        dec.carryFromFlag = (opSel == OP_SUBDB) || (opSel == OP_SUBMB);
        dec.carryConst    = 1'b1;
      end
      OP_AND: begin dec.accWr = 1'b1; dec.resSel = RES_AND; end
      OP_OR:  begin dec.accWr = 1'b1; dec.resSel = RES_OR;  end
      OP_XOR: begin dec.accWr = 1'b1; dec.resSel = RES_XOR; end
      OP_SHR, OP_RSHR: begin
        dec.accWr        = 1'b1;
        dec.flagWr       = 1'b1;
        dec.resSel       = RES_SHR;
        dec.fillFromFlag = (opSel == OP_RSHR);
      end
      OP_SHL, OP_RSHL: begin
        dec.accWr        = 1'b1;
        dec.flagWr       = 1'b1;
        dec.resSel       = RES_SHL;
        dec.fillFromFlag = (opSel == OP_RSHL);
      end
      default: dec = '0;
    endcase
  end

  always_comb begin
    strobes        = dec;
    strobes.accWr  = dec.accWr  & loadEn;
    strobes.flagWr = dec.flagWr & loadEn;
  end
endmodule

// File: rtl/accum_alu_adder.sv
`timescale 1ns/1ps
module accum_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             cIn,
  output logic [WIDTH:0]   sumOut
);
  localparam int SUM_W = WIDTH + 1;

  always_comb begin
    sumOut = {1'b0, aIn} + {1'b0, bIn} + {{(SUM_W-1){1'b0}}, cIn};
  end
endmodule

// File: rtl/accum_alu_dp.sv
`timescale 1ns/1ps
module accum_alu_dp
  import accum_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] accOut,
  output logic             flagOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] accQ, accNext, addA, addBRaw, addB;
  logic             flagQ, flagNext, carryIn, fillBit;
  logic [WIDTH:0]   sumVal;

  always_comb begin
    addA    = strobes.swapOps ? accQ : operand;
    addBRaw = strobes.swapOps ? operand : accQ;
    addB    = strobes.invB ? ~addBRaw : addBRaw;
    carryIn = strobes.carryFromFlag ? flagQ : strobes.carryConst;
    fillBit = strobes.fillFromFlag & flagQ;
  end

  accum_alu_adder #(.WIDTH(WIDTH)) adder_i (
    .aIn   (addA),
    .bIn   (addB),
    .cIn   (carryIn),
    .sumOut(sumVal)
  );

  always_comb begin
    accNext  = operand;
    flagNext = flagQ;
    case (strobes.resSel)
      RES_SUM: begin accNext = sumVal[MSB:0]; flagNext = sumVal[WIDTH]; end
      RES_AND: accNext = operand & accQ;
      RES_OR:  accNext = operand | accQ;
      RES_XOR: accNext = operand ^ accQ;
      RES_SHR: begin accNext = {fillBit, accQ[MSB:1]}; flagNext = accQ[0]; end
      RES_SHL: begin accNext = {accQ[MSB-1:0], fillBit}; flagNext = accQ[MSB]; end
      default: accNext = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strobes.accWr)  accQ  <= accNext;
      if (strobes.flagWr) flagQ <= flagNext;
    end
  end

  assign accOut  = accQ;
  assign flagOut = flagQ;
endmodule

// File: rtl/accum_alu.sv
`timescale 1ns/1ps
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic              flagOut
);
  strobe_t strobes;

  accum_alu_ctrl ctrl_i (
    .loadEn (loadEn),
    .opSel  (opSel),
    .strobes(strobes)
  );

  accum_alu_dp #(.WIDTH(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .operand(operand),
    .accOut (accOut),
    .flagOut(flagOut)
  );
endmodule

// File: rtl/accum_alu_chk.sv
`timescale 1ns/1ps
module accum_alu_chk
  import accum_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] accOut,
  input logic              flagOut
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (accOut == '0) && !flagOut);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(accOut) && $stable(flagOut));

  a_r3_load_pass: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == OP_LOAD) |=> (accOut == $past(operand)) && $stable(flagOut));

  a_r8_logic_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR)) |=> $stable(flagOut));

  a_r9_shr_outbit: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == OP_SHR) |=> (flagOut == $past(accOut[0])) && !accOut[DATA_W-1]);

  a_r10_rshl_ring: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == OP_RSHL) |=>
      (accOut[0] == $past(flagOut)) && (flagOut == $past(accOut[DATA_W-1])));

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel >= 4'd14) |=> $stable(accOut) && $stable(flagOut));
endmodule

bind accum_alu accum_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .loadEn (loadEn),
  .opSel  (opSel),
  .operand(operand),
  .accOut (accOut),
  .flagOut(flagOut)
);

// File: tb/accum_alu_tb_top.sv
`timescale 1ns/1ps
module accum_alu_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] opSel = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] accOut;
  logic       flagOut;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  typedef struct {
    logic [8:0] expVal;
    string      tag;
    logic [3:0] op;
  } item_t;
  item_t sbq[$];

  logic [7:0] mAcc = 8'd0;
  logic       mFlag = 1'b0;

  always #2.5 clk = ~clk;

  accum_alu dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .opSel(opSel),
    .operand(operand), .accOut(accOut), .flagOut(flagOut)
  );

  function automatic logic [8:0] refModel(logic [3:0] op, logic [7:0] a, logic [7:0] d, logic f);
    int r;
    case (op)
      4'd0:  return {f, a};
      4'd1:  begin r = int'(a) + int'(d);            return {r > 255, r[7:0]}; end
      4'd2:  begin r = int'(a) + int'(d) + int'(f);  return {r > 255, r[7:0]}; end
      4'd3:  begin r = int'(a) - int'(d);            return {r >= 0, r[7:0]}; end
      4'd4:  begin r = int'(a) - int'(d) - (1 - int'(f)); return {r >= 0, r[7:0]}; end
      4'd5:  begin r = int'(d) - int'(a);            return {r >= 0, r[7:0]}; end
      4'd6:  begin r = int'(d) - int'(a) - (1 - int'(f)); return {r >= 0, r[7:0]}; end
      4'd7:  return {f, a & d};
      4'd8:  return {f, a | d};
      4'd9:  return {f, a ^ d};
      4'd10: return {d[0], 1'b0, d[7:1]};
      4'd11: return {d[0], f, d[7:1]};
      4'd12: return {d[7], d[6:0], 1'b0};
      4'd13: return {d[7], d[6:0], f};
      default: return {f, d};
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd0:              return "R3";
      4'd1, 4'd2:        return "R4";
      4'd3:              return "R5";
      4'd5:              return "R6";
      4'd4, 4'd6:        return "R7";
      4'd7, 4'd8, 4'd9:  return "R8";
      4'd10, 4'd12:      return "R9";
      4'd11, 4'd13:      return "R10";
      default:           return "R11";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic en);
    item_t it;
    @(negedge clk);
    loadEn  = en;
    opSel   = op;
    operand = a;
    if (en) {mFlag, mAcc} = refModel(op, a, mAcc, mFlag);
    it.expVal = {mFlag, mAcc};
    it.tag    = en ? reqOf(op) : "R2";
    it.op     = op;
    sbq.push_back(it);
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: results appear one edge after the inputs were driven
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check($sformatf("%s op=%0d", it.tag, it.op), {flagOut, accOut}, it.expVal);
      end
    end
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset clears even with a load strobe present
    loadEn = 1'b1; opSel = 4'd0; operand = 8'hA5;
    repeat (4) @(negedge clk);
    check("R1 reset", {flagOut, accOut}, 9'h000);
    rstN = 1'b1; loadEn = 1'b0;

    // directed corners
    drive(4'd0, 8'hFF, 1'b1);          // R3 load
    drive(4'd1, 8'h01, 1'b1);          // R4 FF+01 -> carry, 00
    drive(4'd2, 8'h00, 1'b1);          // R4 00+00+1 -> 01
    drive(4'd0, 8'h05, 1'b1);
    drive(4'd3, 8'h05, 1'b1);          // R5 5-5 -> 0, no borrow
    drive(4'd0, 8'h05, 1'b1);
    drive(4'd3, 8'h04, 1'b1);          // R5 4-5 -> FF, borrow
    drive(4'd4, 8'h00, 1'b1);          // R7 0-FF-1 -> 00, borrow
    drive(4'd0, 8'h10, 1'b1);
    drive(4'd5, 8'h11, 1'b1);          // R6 10-11 -> FF, borrow
    drive(4'd6, 8'h00, 1'b1);          // R7 FF-0-1 -> FE, no borrow
    drive(4'd14, 8'h33, 1'b1);         // R11
    drive(4'd15, 8'h77, 1'b1);         // R11
    drive(4'd1, 8'h80, 1'b0);          // R2 idle
    drive(4'd9, 8'hFF, 1'b0);          // R2 idle

    // every select with both flag values and random data
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 2; f++) begin
        for (int k = 0; k < 12; k++) begin
          drive(4'd0, {7'd0, f[0]}, 1'b1);
          drive(4'd10, 8'h00, 1'b1);   // flag := f
          drive(4'd0, 8'($urandom), 1'b1);
          drive(op[3:0], 8'($urandom), 1'b1);
          drive(4'(op), 8'($urandom), 1'b0);  // R2 idle after each
        end
      end
    end

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule